// File: doc/BRIEF.md
# Three-Phase PWM Timebase with Shadowed Updates

This block is the timing core of a center-aligned three-phase PWM. A triangular counter falls from the active half-period value to zero and then climbs back, so one switching period takes twice the half-period value in clock cycles. Software writes period, dead time, minimum pulse width, sync width, three phase duties and an output-segment word into shadow copies. The shadow set moves into the active set only at defined update points. The downstream comparators and dead-time stage read the active set, so they never see a half-written configuration.

At the start of every period an update occurs, and a sync pulse of programmable width goes out. When the double-update mode input is high, a second update and sync pulse happen at the counter's turnaround. This allows asymmetric patterns and halves the control latency. A half-cycle flag tells a service routine whether the current update belongs to the first half or the second half of the period. A half-period value of zero parks the timebase.

Top module: `pwm_timebase`

## Requirements
- R1: After reset the counter is 0, the sync output and half flag are low, and every active and shadow field is 0, except sync width, which is 39 in both copies.
- R2: A write selects a shadow field by `wr_sel` (0 half-period, 1 dead time, 2 minimum pulse, 3 sync width, 4/5/6 phase A/B/C duty, 7 segment word), keeps the low bits of `wr_data` that fit the field, and leaves every active output unchanged until the next update.
- R3: With active half-period P > 0, the counter takes the values P, P-1, ..., 1 on the way down and then 0, 1, ..., P-1 on the way up. The period is therefore 2P cycles.
- R4: At each period start, every active field takes the shadow value, and the counter restarts at the new half-period.
- R5: When `dbl_mode` is 0, the turnaround causes no update and no sync pulse.
- R6: When `dbl_mode` is 1, the turnaround (the cycle in which the counter shows 0) also loads the active set and starts a sync pulse. The upward leg then runs to the newly loaded half-period.
- R7: The half flag is 0 while the counter is falling and 1 from the turnaround cycle until the next period start.
- R8: Each update that leaves a nonzero half-period starts a sync pulse of (sync width + 1) cycles. The width used is the one loaded by that same update. A new update restarts the pulse.
- R9: When the active half-period is 0, the counter holds at 0 and there is no sync pulse. Once the shadow half-period is nonzero, the next clock edge starts a period.
- R10: A write in the same cycle as an update reaches only the shadow copy. The active set takes the value the shadow held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Shadow write strobe |
| wr_sel | input | 3 | Shadow field select |
| wr_data | input | CNT_W | Write data |
| dbl_mode | input | 1 | 1 selects double update mode |
| cnt_o | output | CNT_W | Triangular counter value |
| half_o | output | 1 | Half-cycle flag |
| sync_o | output | 1 | Sync pulse |
| act_period_o | output | CNT_W | Active half-period |
| act_dead_o | output | DT_W | Active dead time |
| act_minpw_o | output | PW_W | Active minimum pulse width |
| act_syncw_o | output | SW_W | Active sync width |
| act_duty_a_o | output | CNT_W | Active phase A duty |
| act_duty_b_o | output | CNT_W | Active phase B duty |
| act_duty_c_o | output | CNT_W | Active phase C duty |
| act_seg_o | output | SEG_W | Active segment word |

## Verification
All outputs are registered. An update event decided in one cycle shows on the counter, the half flag, the sync output and the active set right after the next rising edge. A shadow write therefore reaches the active outputs no sooner than the second edge after its strobe: one edge to land in the shadow and one for the update. The bench drives inputs and samples outputs on falling edges only, and steps its reference model on the same rising edge the design uses. As a result, every comparison lines up with this one-edge latency, and the directed checks for coincident writes and mid-period writes sample exactly one edge after the stimulus.

// File: rtl/pwm_tbase_pkg.sv
`timescale 1ns/1ps
package pwm_tbase_pkg;
  localparam int SEL_W      = 3;
  localparam int IDX_PERIOD = 0;
  localparam int IDX_DEAD   = 1;
  localparam int IDX_MINPW  = 2;
  localparam int IDX_SYNCW  = 3;
  localparam int IDX_DUTY_A = 4;
  localparam int IDX_DUTY_B = 5;
  localparam int IDX_DUTY_C = 6;
  localparam int IDX_SEG    = 7;
endpackage

// File: rtl/pwm_sync_gen.sv
`timescale 1ns/1ps
module pwm_sync_gen #(
  parameter int SW_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fire,
  input  logic            kill,
  input  logic [SW_W-1:0] width,
  output logic            sync_o
);
  localparam int LEN_W = SW_W + 1;

  // pulse length in cycles for a programmed width value
  function automatic logic [LEN_W-1:0] pulse_len(input logic [SW_W-1:0] w);
    return {1'b0, w} + LEN_W'(1);
  endfunction

  logic [LEN_W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               left_q <= '0;
    else if (fire)            left_q <= pulse_len(width);
    else if (kill)            left_q <= '0;
    else if (left_q != '0)    left_q <= left_q - LEN_W'(1);
  end

  assign sync_o = (left_q != '0);

  assert_sync_fire_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> sync_o);
  assert_sync_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (left_q > LEN_W'(1) && !fire && !kill) |=> sync_o);
endmodule

// File: rtl/pwm_count_core.sv
`timescale 1ns/1ps
module pwm_count_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dbl_mode,
  input  logic [CNT_W-1:0] act_period,
  input  logic [CNT_W-1:0] shd_period,
  output logic [CNT_W-1:0] cnt_o,
  output logic             up_o,
  output logic             start_evt,
  output logic             turn_evt,
  output logic             upd_evt,
  output logic             load_zero
);
  localparam int EXT_W = CNT_W + 1;

  // upward leg is over once the next value would reach the half-period
  function automatic logic top_reached(input logic [CNT_W-1:0] c,
                                       input logic [CNT_W-1:0] p);
    return ({1'b0, c} + EXT_W'(1)) >= {1'b0, p};
  endfunction

  logic [CNT_W-1:0] cnt_q;
  logic             up_q;
  logic             idle;

  assign idle      = (act_period == '0);
  assign start_evt = idle ? (shd_period != '0) : (up_q && top_reached(cnt_q, act_period));
  assign turn_evt  = !idle && !up_q && (cnt_q <= CNT_W'(1));
  assign upd_evt   = start_evt || (turn_evt && dbl_mode);
  assign load_zero = upd_evt && (shd_period == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      up_q  <= 1'b0;
    end else if (load_zero) begin
      cnt_q <= '0;
      up_q  <= 1'b0;
    end else if (start_evt) begin
      cnt_q <= shd_period;
      up_q  <= 1'b0;
    end else if (turn_evt) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (!idle) begin
      cnt_q <= up_q ? cnt_q + CNT_W'(1) : cnt_q - CNT_W'(1);
    end
  end

  assign cnt_o = cnt_q;
  assign up_o  = up_q;

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |-> (cnt_q <= act_period));
  assert_start_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && shd_period != '0) |=> (cnt_q == act_period) && !up_q);
  assert_turn_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(up_q) |-> (cnt_q == '0));
  assert_idle_park_R9: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (cnt_q == '0) && !up_q);
endmodule

// File: rtl/pwm_timebase.sv
`timescale 1ns/1ps
module pwm_timebase
  import pwm_tbase_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int DT_W     = 10,
  parameter int PW_W     = 10,
  parameter int SW_W     = 8,
  parameter int SEG_W    = 9,
  parameter int SYNC_RST = 39
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             dbl_mode,
  output logic [CNT_W-1:0] cnt_o,
  output logic             half_o,
  output logic             sync_o,
  output logic [CNT_W-1:0] act_period_o,
  output logic [DT_W-1:0]  act_dead_o,
  output logic [PW_W-1:0]  act_minpw_o,
  output logic [SW_W-1:0]  act_syncw_o,
  output logic [CNT_W-1:0] act_duty_a_o,
  output logic [CNT_W-1:0] act_duty_b_o,
  output logic [CNT_W-1:0] act_duty_c_o,
  output logic [SEG_W-1:0] act_seg_o
);
  typedef struct packed {
    logic [CNT_W-1:0] period;
    logic [DT_W-1:0]  dead;
    logic [PW_W-1:0]  minpw;
    logic [SW_W-1:0]  syncw;
    logic [CNT_W-1:0] duty_a;
    logic [CNT_W-1:0] duty_b;
    logic [CNT_W-1:0] duty_c;
    logic [SEG_W-1:0] seg;
  } cfg_t;

  function automatic cfg_t cfg_reset();
    cfg_t c = '0;
    c.syncw = SW_W'(SYNC_RST);
    return c;
  endfunction

  cfg_t shd_q, act_q;
  logic start_evt, turn_evt, upd_evt, load_zero, up;

  // shadow copies: the only target of the write port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shd_q <= cfg_reset();
    else if (wr_en) begin
      case (int'(wr_sel))
        IDX_PERIOD: shd_q.period <= wr_data;
        IDX_DEAD:   shd_q.dead   <= wr_data[DT_W-1:0];
        IDX_MINPW:  shd_q.minpw  <= wr_data[PW_W-1:0];
        IDX_SYNCW:  shd_q.syncw  <= wr_data[SW_W-1:0];
        IDX_DUTY_A: shd_q.duty_a <= wr_data;
        IDX_DUTY_B: shd_q.duty_b <= wr_data;
        IDX_DUTY_C: shd_q.duty_c <= wr_data;
        default:    shd_q.seg    <= wr_data[SEG_W-1:0];
      endcase
    end
  end

  // active copies: loaded whole at update points
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       act_q <= cfg_reset();
    else if (upd_evt) act_q <= shd_q;
  end

  pwm_count_core #(.CNT_W(CNT_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .dbl_mode   (dbl_mode),
    .act_period (act_q.period),
    .shd_period (shd_q.period),
    .cnt_o      (cnt_o),
    .up_o       (up),
    .start_evt  (start_evt),
    .turn_evt   (turn_evt),
    .upd_evt    (upd_evt),
    .load_zero  (load_zero)
  );

  pwm_sync_gen #(.SW_W(SW_W)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire   (upd_evt && !load_zero),
    .kill   (load_zero),
    .width  (shd_q.syncw),
    .sync_o (sync_o)
  );

  assign half_o       = up;
  assign act_period_o = act_q.period;
  assign act_dead_o   = act_q.dead;
  assign act_minpw_o  = act_q.minpw;
  assign act_syncw_o  = act_q.syncw;
  assign act_duty_a_o = act_q.duty_a;
  assign act_duty_b_o = act_q.duty_b;
  assign act_duty_c_o = act_q.duty_c;
  assign act_seg_o    = act_q.seg;

  assert_active_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_evt |=> $stable(act_q));
  assert_single_no_mid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (turn_evt && !dbl_mode && !sync_o) |=> !sync_o);
  assert_double_mid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (turn_evt && dbl_mode && shd_q.period != '0) |=> sync_o && half_o);
  assert_coincident_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_evt && wr_en && int'(wr_sel) == IDX_DUTY_B) |=> (act_q.duty_b == $past(shd_q.duty_b)));
endmodule

// File: tb/tb_pwm_timebase.sv
`timescale 1ns/1ps
module tb_pwm_timebase;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic        dbl_mode = 1'b0;
  logic [15:0] cnt_o, act_period_o, act_duty_a_o, act_duty_b_o, act_duty_c_o;
  logic [9:0]  act_dead_o, act_minpw_o;
  logic [7:0]  act_syncw_o;
  logic [8:0]  act_seg_o;
  logic        half_o, sync_o;

  pwm_timebase dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .dbl_mode(dbl_mode), .cnt_o(cnt_o), .half_o(half_o), .sync_o(sync_o),
    .act_period_o(act_period_o), .act_dead_o(act_dead_o), .act_minpw_o(act_minpw_o),
    .act_syncw_o(act_syncw_o), .act_duty_a_o(act_duty_a_o), .act_duty_b_o(act_duty_b_o),
    .act_duty_c_o(act_duty_c_o), .act_seg_o(act_seg_o)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state, indexed by field select
  int m_cnt, m_up, m_sync;
  int m_act[8];
  int m_shd[8];
  int widths[8] = '{16, 10, 10, 8, 16, 16, 16, 9};

  function automatic bit m_update_due();
    bit idle = (m_act[0] == 0);
    bit start = idle ? (m_shd[0] != 0) : (m_up == 1 && m_cnt + 1 >= m_act[0]);
    bit turn = !idle && m_up == 0 && m_cnt <= 1;
    return start || (turn && dbl_mode);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_up = 0; m_sync = 0;
      for (int i = 0; i < 8; i++) begin m_act[i] = 0; m_shd[i] = 0; end
      m_act[3] = 39; m_shd[3] = 39;
    end else begin
      bit idle, start, turn, upd;
      idle  = (m_act[0] == 0);
      start = idle ? (m_shd[0] != 0) : (m_up == 1 && m_cnt + 1 >= m_act[0]);
      turn  = !idle && m_up == 0 && m_cnt <= 1;
      upd   = start || (turn && dbl_mode);
      if (upd) for (int i = 0; i < 8; i++) m_act[i] = m_shd[i];
      if (upd && m_shd[0] == 0) begin
        m_cnt = 0; m_up = 0; m_sync = 0;
      end else begin
        if (start) begin m_cnt = m_shd[0]; m_up = 0; end
        else if (turn) begin m_cnt = 0; m_up = 1; end
        else if (!idle) m_cnt = m_up ? m_cnt + 1 : m_cnt - 1;
        if (upd) m_sync = m_shd[3] + 1;
        else if (m_sync > 0) m_sync--;
      end
      if (wr_en) m_shd[wr_sel] = int'(wr_data) & ((1 << widths[wr_sel]) - 1);
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int dut_act(input int i);
    case (i)
      0: return int'(act_period_o);
      1: return int'(act_dead_o);
      2: return int'(act_minpw_o);
      3: return int'(act_syncw_o);
      4: return int'(act_duty_a_o);
      5: return int'(act_duty_b_o);
      6: return int'(act_duty_c_o);
      default: return int'(act_seg_o);
    endcase
  endfunction

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(int'(cnt_o) == m_cnt, "R3 counter", int'(cnt_o), m_cnt);
      chk(int'(half_o) == m_up, "R7 half flag", int'(half_o), m_up);
      chk(int'(sync_o) == int'(m_sync > 0), dbl_mode ? "R6/R8 sync" : "R5/R8 sync",
          int'(sync_o), int'(m_sync > 0));
      for (int i = 0; i < 8; i++)
        chk(dut_act(i) == m_act[i], "R4 active field", dut_act(i), m_act[i]);
    end
  end

  task automatic wr(input int sel, input int data);
    wr_en = 1'b1; wr_sel = 3'(sel); wr_data = 16'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic count_rises(input int n, output int rises);
    bit prev = sync_o;
    rises = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (sync_o && !prev) rises++;
      prev = sync_o;
    end
  endtask

  task automatic summary();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int r;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values
    chk(cnt_o == 0 && !sync_o && !half_o, "R1 outputs idle", int'(cnt_o), 0);
    chk(act_syncw_o == 39, "R1 sync width reset", int'(act_syncw_o), 39);
    chk(act_period_o == 0, "R1 period reset", int'(act_period_o), 0);

    // R9 parked with zero half-period
    count_rises(10, r);
    chk(r == 0 && !sync_o, "R9 no sync when parked", r, 0);
    chk(cnt_o == 0, "R9 counter parked", int'(cnt_o), 0);

    // R2 writes stay in shadow while parked
    wr(3, 1);
    wr(4, 100);
    chk(act_syncw_o == 39, "R2 sync width not yet active", int'(act_syncw_o), 39);
    chk(act_duty_a_o == 0, "R2 duty A not yet active", int'(act_duty_a_o), 0);
    wr(0, 6);
    @(negedge clk);
    chk(cnt_o == 6 && sync_o, "R9 start one edge after period write", int'(cnt_o), 6);
    chk(act_duty_a_o == 100, "R4 duty loaded at start", int'(act_duty_a_o), 100);

    // R5 single update: one pulse per 12-cycle period
    repeat (30) @(negedge clk);
    count_rises(48, r);
    chk(r == 4, "R5 single mode pulse count", r, 4);

    // R6 double update: two pulses per period
    dbl_mode = 1'b1;
    repeat (30) @(negedge clk);
    count_rises(48, r);
    chk(r == 8, "R6 double mode pulse count", r, 8);

    // R10 write coinciding with an update
    do @(negedge clk); while (!m_update_due());
    wr(5, 16'h1234);
    chk(act_duty_b_o == 0, "R10 coincident write not active", int'(act_duty_b_o), 0);

    // R2 mid-period write has no effect until update
    do @(negedge clk); while (m_update_due());
    wr(6, 777);
    chk(act_duty_c_o == 0, "R2 mid-period write held", int'(act_duty_c_o), 0);

    // randomized traffic, model compared every cycle
    for (int k = 0; k < 2000; k++) begin
      if (k % 200 == 0) dbl_mode = ~dbl_mode;
      if ($urandom_range(0, 3) == 0) begin
        int sel = $urandom_range(0, 7);
        int data = (sel == 0) ? $urandom_range(0, 9) :
                   (sel == 3) ? $urandom_range(0, 15) : $urandom_range(0, 65535);
        wr(sel, data);
      end else @(negedge clk);
    end

    // R9 return to parked state
    wr(0, 0);
    repeat (60) @(negedge clk);
    count_rises(20, r);
    chk(r == 0 && !sync_o, "R9 parked after zero period", r, 0);
    chk(cnt_o == 0 && !half_o, "R9 counter held at zero", int'(cnt_o), 0);
    summary();
  end
endmodule